// File: doc/BRIEF.md
# DSP Control Command Frame Parser

This block sits behind a byte-oriented serial control port. It interprets each framed transaction that arrives from that port. The first byte of a frame is a command byte. It carries a direction flag, a three-bit area field and a four-bit sub-code. The parser decodes the command byte into a target code. For memory areas it then collects a big-endian 16-bit start address. After that it steers the following data bytes to a write strobe, or raises a read request when the command is a read.

Memory targets take data words of `WORD_BYTES` bytes each, sent most significant byte first. Every completed word produces one strobe, and the address advances by one after each word. Register-style targets take single-byte words and do not advance. The parser raises a one-cycle error pulse for any undefined command, any direction that the target does not allow, and any address phase cut short by the end of the frame. An erroneous frame is then ignored until the frame-active input drops. Dropping frame-active at any point returns the parser to waiting for a command byte and throws away partial state.

Top module: `cmd_frame_parser`

## Requirements
- R1: Bit 7 of the command byte is the direction (1 = write, 0 = read). Targets 1–7 and 13 are write-only. Targets 10, 11 and 14–17 are read-only. Targets 8, 9 and 12 allow both. Using a target in a direction it does not allow pulses `err`.
- R2: Area codes 0–3 (bits 6:4) are followed by two address bytes, high byte first. Together they form the address used for the first data word.
- R3: Area codes 4–7 take no address phase, and data follows the command byte at once. Area 4 accepts register index 0–8 and area 5 accepts index 0–1, both taken from bits 3:0. Any larger index pulses `err`.
- R4: The `tgt` code follows this map, written as area/sub-code → code. 0/any→1, 1/any→2, 2/0100→3, 2/0010→4, 2/1000→5, 3/0100→6, 3/0010→7, 4→8, 5→9, 6/0000→10, 7/0000→11, 7/0010→12, 7/0100→13, 7/0110→14, 7/1000→15, 7/1010→16, 7/1100→17. Code 0 means no target.
- R5: For memory targets (codes 1–7), each group of `WORD_BYTES` data bytes produces exactly one `wr_stb`. The word is assembled most significant byte first. No strobe appears mid-word. Each further word uses the previous address plus one, wrapping modulo 2^16.
- R6: For write-capable targets without an address phase, every data byte produces one `wr_stb`. The byte appears zero-extended in `wr_data`. `acc_addr` is the register index for codes 8 and 9 and 0 for other codes, and it never advances.
- R7: A valid read command produces one `rd_req` pulse, with `acc_addr` set as in R6. Later bytes in that frame produce no strobe.
- R8: An undefined area/sub-code combination pulses `err` once. `tgt` then reads 0, and the rest of the frame produces no strobe or request.
- R9: If frame-active drops during the address phase, `err` pulses once. If it drops mid-word, the partial word is discarded with no strobe. Either way the next frame is decoded afresh.
- R10: All outputs are registered and change one cycle after the byte that causes them. `wr_stb`, `rd_req` and `err` are one-cycle pulses and never occur together. `tgt` is 0 whenever the frame is inactive.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_act | input | 1 | High for the duration of a frame |
| byte_vld | input | 1 | A byte is present on byte_data this cycle |
| byte_data | input | 8 | Received byte |
| tgt | output | 5 | Decoded target code (R4), 0 when idle or after an error |
| acc_addr | output | 16 | Address of the current strobe or read request |
| wr_stb | output | 1 | One-cycle write strobe for a completed word |
| wr_data | output | 8*WORD_BYTES | Completed word |
| rd_req | output | 1 | One-cycle read request |
| err | output | 1 | One-cycle error pulse |

## Verification
A wrong word-byte counter shows up at the ports on the very next word. The strobe arrives a byte early or late, and `wr_data` holds shifted bytes. A wrong address pointer shows as a bad `acc_addr` on the first strobe after the address phase, or on the second strobe when the increment is wrong. A wrong state after a decode error or a frame end leaks out as a strobe or a non-zero `tgt` on the next byte. The bench therefore sweeps all 256 command bytes, each followed by data or dummy bytes. It also drives directed frames for wrap-around, partial words and truncated addresses.

// File: rtl/cfp_pkg.sv
package cfp_pkg;

  typedef enum logic [4:0] {
    TGT_NONE      = 5'd0,
    TGT_PREP_COEF = 5'd1,
    TGT_PREP_OFS  = 5'd2,
    TGT_COEF_RUN  = 5'd3,
    TGT_OFS_RUN   = 5'd4,
    TGT_PROG_LOAD = 5'd5,
    TGT_COEF_LOAD = 5'd6,
    TGT_OFS_LOAD  = 5'd7,
    TGT_CTRL_REG  = 5'd8,
    TGT_PWR_REG   = 5'd9,
    TGT_DEV_ID    = 5'd10,
    TGT_ERR_STAT  = 5'd11,
    TGT_CRC       = 5'd12,
    TGT_SPECIAL   = 5'd13,
    TGT_MON1      = 5'd14,
    TGT_MON2      = 5'd15,
    TGT_MON3      = 5'd16,
    TGT_MON4      = 5'd17
  } tgt_e;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_DATA,
    ST_HOLD,
    ST_DROP
  } st_e;

  typedef struct packed {
    tgt_e       tgt;
    logic       bad;
    logic       needs_addr;
    logic       is_ram;
    logic       is_rd;
    logic [3:0] index;
  } dec_t;

endpackage

// File: rtl/cfp_cmd_decode.sv
module cfp_cmd_decode
  import cfp_pkg::*;
#(
  parameter int N_CTRL_REGS = 9,
  parameter int N_PWR_REGS  = 2
) (
  input  logic [7:0] cmd,
  output dec_t       dec
);

  localparam logic [4:0] CTRL_LIM = 5'(N_CTRL_REGS);
  localparam logic [4:0] PWR_LIM  = 5'(N_PWR_REGS);

  logic [2:0] area;
  logic [3:0] sub;
  logic       can_rd;
  logic       can_wr;
  tgt_e       t;

  assign area = cmd[6:4];
  assign sub  = cmd[3:0];

  always_comb begin
    t = TGT_NONE;
    unique case (area)
      3'd0: t = TGT_PREP_COEF;
      3'd1: t = TGT_PREP_OFS;
      3'd2: begin
        case (sub)
          4'b0100: t = TGT_COEF_RUN;
          4'b0010: t = TGT_OFS_RUN;
          4'b1000: t = TGT_PROG_LOAD;
          default: t = TGT_NONE;
        endcase
      end
      3'd3: begin
        case (sub)
          4'b0100: t = TGT_COEF_LOAD;
          4'b0010: t = TGT_OFS_LOAD;
          default: t = TGT_NONE;
        endcase
      end
      3'd4: t = ({1'b0, sub} < CTRL_LIM) ? TGT_CTRL_REG : TGT_NONE;
      3'd5: t = ({1'b0, sub} < PWR_LIM)  ? TGT_PWR_REG  : TGT_NONE;
      3'd6: t = (sub == 4'b0000) ? TGT_DEV_ID : TGT_NONE;
      default: begin
        case (sub)
          4'b0000: t = TGT_ERR_STAT;
          4'b0010: t = TGT_CRC;
          4'b0100: t = TGT_SPECIAL;
          4'b0110: t = TGT_MON1;
          4'b1000: t = TGT_MON2;
          4'b1010: t = TGT_MON3;
          4'b1100: t = TGT_MON4;
          default: t = TGT_NONE;
        endcase
      end
    endcase
  end

  always_comb begin
    can_rd = 1'b0;
    can_wr = 1'b0;
    case (t)
      TGT_PREP_COEF, TGT_PREP_OFS, TGT_COEF_RUN, TGT_OFS_RUN,
      TGT_PROG_LOAD, TGT_COEF_LOAD, TGT_OFS_LOAD, TGT_SPECIAL: can_wr = 1'b1;
      TGT_DEV_ID, TGT_ERR_STAT, TGT_MON1, TGT_MON2, TGT_MON3, TGT_MON4: can_rd = 1'b1;
      TGT_CTRL_REG, TGT_PWR_REG, TGT_CRC: begin
        can_rd = 1'b1;
        can_wr = 1'b1;
      end
      default: begin
        can_rd = 1'b0;
        can_wr = 1'b0;
      end
    endcase
  end

  always_comb begin
    dec            = '0;
    dec.tgt        = t;
    dec.is_rd      = ~cmd[7];
    dec.is_ram     = ~area[2];
    dec.needs_addr = ~area[2];
    dec.index      = (t == TGT_CTRL_REG || t == TGT_PWR_REG) ? sub : 4'd0;
    dec.bad        = (t == TGT_NONE) || (cmd[7] ? ~can_wr : ~can_rd);
  end

endmodule

// File: rtl/cfp_word_pack.sv
module cfp_word_pack #(
  parameter int WORD_BYTES = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    push,
  input  logic                    multi,
  input  logic [7:0]              byte_in,
  output logic                    done,
  output logic [WORD_BYTES*8-1:0] word
);

  localparam int W     = WORD_BYTES * 8;
  localparam int CNT_W = $clog2(WORD_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BYTES - 1);

  logic [W-9:0]     hold_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     word_full;

  assign word_full = {hold_q, byte_in};
  assign done      = push && (!multi || cnt_q == LAST);
  assign word      = multi ? word_full : W'(byte_in);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else if (push) begin
      cnt_q  <= done ? '0 : cnt_q + 1'b1;
      hold_q <= word_full[W-9:0];
    end
  end

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  p_single_no_count_r6: assert property (@(posedge clk) disable iff (rst)
    (push && !multi) |=> cnt_q == '0);

endmodule

// File: rtl/cmd_frame_parser.sv
module cmd_frame_parser
  import cfp_pkg::*;
#(
  parameter int WORD_BYTES  = 3,
  parameter int N_CTRL_REGS = 9,
  parameter int N_PWR_REGS  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frame_act,
  input  logic                    byte_vld,
  input  logic [7:0]              byte_data,
  output logic [4:0]              tgt,
  output logic [15:0]             acc_addr,
  output logic                    wr_stb,
  output logic [WORD_BYTES*8-1:0] wr_data,
  output logic                    rd_req,
  output logic                    err
);

  localparam int W = WORD_BYTES * 8;

  st_e         st_q;
  tgt_e        tgt_q;
  logic        ram_q;
  logic [15:0] ptr_q;
  logic [15:0] acc_q;
  logic        wr_stb_q;
  logic [W-1:0] wr_data_q;
  logic        rd_q;
  logic        err_q;

  dec_t        dec;
  logic        pk_clr;
  logic        pk_push;
  logic        pk_done;
  logic [W-1:0] pk_word;

  cfp_cmd_decode #(
    .N_CTRL_REGS(N_CTRL_REGS),
    .N_PWR_REGS (N_PWR_REGS)
  ) u_dec (
    .cmd(byte_data),
    .dec(dec)
  );

  assign pk_clr  = !frame_act || (st_q != ST_DATA);
  assign pk_push = frame_act && byte_vld && (st_q == ST_DATA);

  cfp_word_pack #(.WORD_BYTES(WORD_BYTES)) u_pack (
    .clk    (clk),
    .rst    (rst),
    .clr    (pk_clr),
    .push   (pk_push),
    .multi  (ram_q),
    .byte_in(byte_data),
    .done   (pk_done),
    .word   (pk_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_CMD;
      tgt_q     <= TGT_NONE;
      ram_q     <= 1'b0;
      ptr_q     <= '0;
      acc_q     <= '0;
      wr_stb_q  <= 1'b0;
      wr_data_q <= '0;
      rd_q      <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      wr_stb_q <= 1'b0;
      rd_q     <= 1'b0;
      err_q    <= 1'b0;
      if (!frame_act) begin
        st_q  <= ST_CMD;
        tgt_q <= TGT_NONE;
        ram_q <= 1'b0;
        if (st_q == ST_ADDR_HI || st_q == ST_ADDR_LO) err_q <= 1'b1;
      end else if (byte_vld) begin
        unique case (st_q)
          ST_CMD: begin
            if (dec.bad) begin
              err_q <= 1'b1;
              tgt_q <= TGT_NONE;
              st_q  <= ST_DROP;
            end else begin
              tgt_q <= dec.tgt;
              ram_q <= dec.is_ram;
              if (dec.needs_addr) begin
                st_q <= ST_ADDR_HI;
              end else if (dec.is_rd) begin
                rd_q  <= 1'b1;
                acc_q <= {12'd0, dec.index};
                st_q  <= ST_HOLD;
              end else begin
                ptr_q <= {12'd0, dec.index};
                st_q  <= ST_DATA;
              end
            end
          end
          ST_ADDR_HI: begin
            ptr_q[15:8] <= byte_data;
            st_q        <= ST_ADDR_LO;
          end
          ST_ADDR_LO: begin
            ptr_q[7:0] <= byte_data;
            st_q       <= ST_DATA;
          end
          ST_DATA: begin
            if (pk_done) begin
              wr_stb_q  <= 1'b1;
              wr_data_q <= pk_word;
              acc_q     <= ptr_q;
              if (ram_q) ptr_q <= ptr_q + 16'd1;
            end
          end
          default: st_q <= st_q;
        endcase
      end
    end
  end

  assign tgt      = tgt_q;
  assign acc_addr = acc_q;
  assign wr_stb   = wr_stb_q;
  assign wr_data  = wr_data_q;
  assign rd_req   = rd_q;
  assign err      = err_q;

  p_pulses_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_stb_q, rd_q, err_q}));

  p_idle_no_tgt_r10: assert property (@(posedge clk) disable iff (rst)
    !frame_act |=> tgt_q == TGT_NONE);

  p_ram_step_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_stb_q && ram_q) |-> ptr_q == acc_q + 16'd1);

  p_reg_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_stb_q && !ram_q) |-> ptr_q == acc_q);

  p_rd_has_tgt_r7: assert property (@(posedge clk) disable iff (rst)
    rd_q |-> (tgt_q != TGT_NONE && st_q == ST_HOLD));

  p_err_drops_r8: assert property (@(posedge clk) disable iff (rst)
    (err_q && frame_act) |-> (st_q == ST_DROP && tgt_q == TGT_NONE));

  p_drop_silent_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DROP && frame_act) |=> !wr_stb_q && !rd_q);

endmodule

// File: tb/cmd_frame_parser_tb.sv
module cmd_frame_parser_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WB = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_act = 1'b0;
  logic          byte_vld = 1'b0;
  logic [7:0]    byte_data = 8'h00;
  logic [4:0]    tgt;
  logic [15:0]   acc_addr;
  logic          wr_stb;
  logic [WB*8-1:0] wr_data;
  logic          rd_req;
  logic          err;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_frame_parser #(.WORD_BYTES(WB)) u_dut (
    .clk(clk), .rst(rst), .frame_act(frame_act), .byte_vld(byte_vld),
    .byte_data(byte_data), .tgt(tgt), .acc_addr(acc_addr), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_req(rd_req), .err(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    byte_vld  = 1'b1;
    byte_data = b;
    @(negedge clk);
    byte_vld  = 1'b0;
  endtask

  task automatic start_frame();
    @(negedge clk);
    frame_act = 1'b1;
  endtask

  task automatic end_frame();
    @(negedge clk);
    frame_act = 1'b0;
    @(negedge clk);
  endtask

  function automatic int ref_tgt(input logic [7:0] c);
    int a = int'(c[6:4]);
    int s = int'(c[3:0]);
    case (a)
      0: return 1;
      1: return 2;
      2: return (s == 4) ? 3 : (s == 2) ? 4 : (s == 8) ? 5 : 0;
      3: return (s == 4) ? 6 : (s == 2) ? 7 : 0;
      4: return (s < 9) ? 8 : 0;
      5: return (s < 2) ? 9 : 0;
      6: return (s == 0) ? 10 : 0;
      default: begin
        if (s == 0) return 11;
        if (s == 2) return 12;
        if (s == 4) return 13;
        if (s >= 6 && s <= 12 && (s % 2) == 0) return 14 + (s - 6) / 2;
        return 0;
      end
    endcase
  endfunction

  function automatic bit ref_bad(input logic [7:0] c);
    int t = ref_tgt(c);
    bit wr = c[7];
    bit ro = (t == 10 || t == 11 || (t >= 14 && t <= 17));
    bit wo = ((t >= 1 && t <= 7) || t == 13);
    return (t == 0) || (wr && ro) || (!wr && wo);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 tgt", 32'(tgt), 0);
    chk("R11 addr", 32'(acc_addr), 0);
    chk("R11 pulses", {29'd0, wr_stb, rd_req, err}, 0);
    chk("R11 data", 32'(wr_data), 0);
    @(negedge clk);
    rst = 1'b0;

    // R1 R3 R4 R6 R7 R8: sweep every command byte
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cb = 8'(c);
      int t = ref_tgt(cb);
      bit bad = ref_bad(cb);
      int idx = (t == 8 || t == 9) ? int'(cb[3:0]) : 0;
      start_frame();
      send(cb);
      chk("R4 tgt", 32'(tgt), bad ? 0 : t);
      chk("R1/R8 err", 32'(err), 32'(bad));
      chk("R7 rd_req", 32'(rd_req), 32'(!bad && !cb[7]));
      if (!bad && !cb[7]) chk("R7 rd addr", 32'(acc_addr), idx);
      if (bad) begin
        send(8'h5A);
        chk("R8 drop strobe", {30'd0, wr_stb, rd_req}, 0);
        chk("R8 drop tgt", 32'(tgt), 0);
      end else if (!cb[7]) begin
        send(8'h33);
        chk("R7 no strobe", 32'(wr_stb), 0);
      end else if (cb[6:4] < 3'd4) begin
        // R2 R5
        send(cb);
        send(~cb);
        chk("R2 no strobe in addr", 32'(wr_stb), 0);
        send(cb); send(8'h11);
        chk("R5 mid-word", 32'(wr_stb), 0);
        send(8'h22);
        chk("R5 stb1", 32'(wr_stb), 1);
        chk("R2 addr1", 32'(acc_addr), {16'd0, cb, ~cb});
        chk("R5 data1", 32'(wr_data), {8'd0, cb, 8'h11, 8'h22});
        send(8'h44); send(8'h55); send(8'h66);
        chk("R5 stb2", 32'(wr_stb), 1);
        chk("R5 addr2", 32'(acc_addr), 32'(16'({cb, ~cb} + 16'd1)));
        chk("R5 data2", 32'(wr_data), 32'h00445566);
      end else begin
        send(8'h9C);
        chk("R6 stb", 32'(wr_stb), 1);
        chk("R6 data", 32'(wr_data), 32'h9C);
        chk("R6 addr", 32'(acc_addr), idx);
        send(8'h3D);
        chk("R6 stb2", 32'(wr_stb), 1);
        chk("R6 addr hold", 32'(acc_addr), idx);
      end
      end_frame();
      chk("R10 idle tgt", 32'(tgt), 0);
      chk("R9 no spurious err", 32'(err), 0);
    end

    // R5 wrap at top of address space
    start_frame();
    send(8'h80); send(8'hFF); send(8'hFF);
    send(8'h01); send(8'h02); send(8'h03);
    chk("R5 wrap addr1", 32'(acc_addr), 32'hFFFF);
    send(8'h04); send(8'h05); send(8'h06);
    chk("R5 wrap addr2", 32'(acc_addr), 0);
    end_frame();

    // R9 partial word discarded
    start_frame();
    send(8'hA4); send(8'h12); send(8'h34);
    send(8'h77); send(8'h88);
    @(negedge clk);
    frame_act = 1'b0;
    @(negedge clk);
    chk("R9 partial no stb", 32'(wr_stb), 0);
    chk("R9 partial no err", 32'(err), 0);
    start_frame();
    send(8'hA4); send(8'h00); send(8'h10);
    send(8'hAA); send(8'hBB); send(8'hCC);
    chk("R9 fresh word", 32'(wr_data), 32'h00AABBCC);
    chk("R9 fresh addr", 32'(acc_addr), 32'h0010);
    end_frame();

    // R9 truncated address: after one byte, and after none
    start_frame();
    send(8'h90); send(8'h12);
    end_frame();
    chk("R9 trunc1 err", 32'(err), 1);
    chk("R9 trunc1 tgt", 32'(tgt), 0);
    @(negedge clk);
    chk("R10 err one cycle", 32'(err), 0);
    start_frame();
    send(8'h80);
    end_frame();
    chk("R9 trunc0 err", 32'(err), 1);

    // R10 frame_act low blocks bytes
    @(negedge clk);
    byte_vld = 1'b1; byte_data = 8'hC0;
    @(negedge clk);
    byte_vld = 1'b0;
    chk("R10 inactive ignored", {26'd0, tgt, rd_req}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule